// File: doc/BRIEF.md
# Packet FIFO Slave Sink

This block is the receiving end of a point-to-point packet link on which the sender pushes words and the receiver has no per-cycle way to stall it. On every rising clock edge where the write enable is high, the block stores the data word together with its start, end, error, empty-byte count, parity and address side information. It stores one word per cycle, in arrival order. On the data bus the first byte of a packet sits in the most significant byte, and bytes follow in big-endian order. The only way the block throttles the sender is a space flag, which stays high while enough free slots remain to absorb a burst.

A sender may keep writing for several cycles after the space flag drops. The threshold therefore leaves headroom below the full mark. If a write still arrives when every slot is taken, the word is discarded. The block then raises a sticky overflow flag and forces the error marker onto the end word of the damaged packet, so that logic downstream discards that packet. On the local side, a first-word-fall-through port presents the oldest stored word whenever one exists, and a pop strobe removes it.

The data width is 8·2^m bits with an m-bit empty-byte count. Parity checking can be switched off, or set to even or odd. Depth and threshold are parameters, and the threshold must lie strictly between zero and the depth.

Top module: `pkt_sink_fifo`

## Requirements
- R1: Each rising edge with `wr_ena` high stores one word (data, start, end flags) in order. With `wr_ena` low, nothing is stored, whatever the other write inputs carry.
- R2: `rd_valid` is high exactly while at least one word is stored, and the read outputs then show the oldest word. `rd_pop` with `rd_valid` high removes that word at the edge. `rd_pop` with `rd_valid` low has no effect.
- R3: `space_ok` is high exactly when the free slots (DEPTH minus stored words) number at least THRESH, judged on the occupancy after each edge.
- R4: A write that arrives while DEPTH words are stored is discarded, and the stored words stay intact. A pop in the same cycle still takes place.
- R5: The first discarded write sets `ovf_flag`, which stays high until reset.
- R6: After a discarded write, the next stored word whose end flag is 1 is stored with error = 1. Packets that end after it are unaffected.
- R7: Otherwise the stored error bit equals the `wr_err` input of that word.
- R8: The stored empty-byte count equals `wr_mty` on words with the end flag set, and is 0 on every other word.
- R9: With even parity (PAR_MODE = 1), a word whose `wr_par` differs from the XOR of its data bits is stored with error = 1, and so is the end word of the same packet.
- R10: After reset, `rd_valid` = 0, `space_ok` = 1 and `ovf_flag` = 0.
- R11: A write and a pop in the same cycle leave the occupancy unchanged, which sustains one word per cycle through the buffer.
- R12: `wr_adr` is stored with each word and returned on `rd_adr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ena | input | 1 | Write strobe; qualifies all write inputs in the same cycle |
| wr_dat | input | DATA_W | Packet data, big-endian, first byte in the MSB lane |
| wr_sop | input | 1 | First word of a packet |
| wr_eop | input | 1 | Last word of a packet |
| wr_err | input | 1 | Sender marks the packet as bad |
| wr_mty | input | MTY_P | Count of unused low-order bytes on the last word |
| wr_par | input | 1 | Parity bit over wr_dat |
| wr_adr | input | ADR_W | Port address carried with the packet |
| space_ok | output | 1 | At least THRESH free slots remain |
| ovf_flag | output | 1 | Sticky: a write was discarded |
| rd_valid | output | 1 | Oldest stored word is presented |
| rd_pop | input | 1 | Remove the presented word |
| rd_dat | output | DATA_W | Stored data |
| rd_sop | output | 1 | Stored start flag |
| rd_eop | output | 1 | Stored end flag |
| rd_err | output | 1 | Stored error flag, including overflow and parity marking |
| rd_mty | output | MTY_P | Stored empty-byte count |
| rd_adr | output | ADR_W | Stored address |

## Verification
The first directed patterns are a short packet with idle gaps that carry junk data, and a non-final word that carries a nonzero empty count. Together they separate capture that is qualified by the strobe from capture that is not, and show whether the empty count is cleaned. A steady write-plus-pop stream tells a buffer that keeps one word per cycle apart from one that loses or duplicates words at equal rates. Writing well past the threshold into a full buffer, then freeing a slot for the end word, separates the cases where late writes are dropped, where they overwrite stored data, and where the error marking lands on the wrong packet. Parity faults, sender errors and a long random mix of packets, idles and pops are then compared each clock against a queue-based model.

// File: rtl/pkt_sink_pkg.sv
package pkt_sink_pkg;

    localparam int PAR_NONE = 0;
    localparam int PAR_EVEN = 1;
    localparam int PAR_ODD  = 2;

    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_STORE = 2'd1,
        WR_DROP  = 2'd2
    } wr_act_e;

    // bits needed to count empty bytes in a data word of data_w bits
    function automatic int mty_bits(input int data_w);
        return $clog2(data_w / 8);
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/pkt_sink_ingress.sv
module pkt_sink_ingress
    import pkt_sink_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int MTY_W    = 2,
    parameter int MTY_P    = 2,
    parameter int ADR_W    = 4,
    parameter int PAR_MODE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ena,
    input  logic [DATA_W-1:0] wr_dat,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic              wr_err,
    input  logic [MTY_P-1:0]  wr_mty,
    input  logic              wr_par,
    input  logic [ADR_W-1:0]  wr_adr,
    input  logic              full,
    output logic              st_en,
    output logic              st_sop,
    output logic              st_eop,
    output logic              st_err,
    output logic [MTY_P-1:0]  st_mty,
    output logic [ADR_W-1:0]  st_adr,
    output logic [DATA_W-1:0] st_dat,
    output logic              ovf
);

    wr_act_e act;
    logic    par_bad;
    logic    taint_q;
    logic    ovf_q;

    generate
        if (PAR_MODE == PAR_NONE) begin : g_par_off
            assign par_bad = 1'b0;
        end else if (PAR_MODE == PAR_ODD) begin : g_par_odd
            assign par_bad = (wr_par == (^wr_dat));
        end else begin : g_par_even
            assign par_bad = (wr_par != (^wr_dat));
        end

        if (MTY_W == 0) begin : g_no_mty
            assign st_mty = '0;
        end else begin : g_mty
            assign st_mty = wr_eop ? wr_mty : '0;
        end
    endgenerate

    always_comb begin
        if (!wr_ena)   act = WR_IDLE;
        else if (full) act = WR_DROP;
        else           act = WR_STORE;
    end

    assign st_en  = (act == WR_STORE);
    assign st_sop = wr_sop;
    assign st_eop = wr_eop;
    assign st_adr = wr_adr;
    assign st_dat = wr_dat;
    assign st_err = wr_err | par_bad | (wr_eop & taint_q);
    assign ovf    = ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            taint_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            case (act)
                WR_DROP: begin
                    taint_q <= 1'b1;
                    ovf_q   <= 1'b1;
                end
                WR_STORE: taint_q <= wr_eop ? 1'b0 : (taint_q | par_bad);
                default:  taint_q <= taint_q;
            endcase
        end
    end

    // R5: a write against a full store must leave the overflow flag set
    p_drop_sets_ovf_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_ena && full) |=> ovf);

    // R5: the flag never falls outside reset
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

endmodule

// File: rtl/pkt_sink_store.sv
module pkt_sink_store #(
    parameter int WORD_W = 41,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop_req,
    output logic [WORD_W-1:0] head_word,
    output logic              nonempty,
    output logic              full,
    output logic [CNT_W-1:0]  count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count_q;
    logic              pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign nonempty  = (count_q != '0);
    assign full      = (count_q == CNT_W'(DEPTH));
    assign pop       = pop_req & nonempty;
    assign head_word = mem[rd_ptr];
    assign count     = count_q;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // R4: the ingress side may only store into a free slot
    p_push_room_r4: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R4: occupancy never exceeds the depth
    p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));

    // R11: matched push and pop keep occupancy steady
    p_count_steady_r11: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> $stable(count_q));

endmodule

// File: rtl/pkt_sink_level.sv
module pkt_sink_level #(
    parameter int DEPTH  = 16,
    parameter int THRESH = 4,
    parameter int CNT_W  = 5
) (
    input  logic [CNT_W-1:0] count,
    output logic             space_ok
);

    logic [CNT_W-1:0] free_slots;

    initial begin
        assert (THRESH > 0 && THRESH < DEPTH);
    end

    assign free_slots = CNT_W'(DEPTH) - count;
    assign space_ok   = (free_slots >= CNT_W'(THRESH));

endmodule

// File: rtl/pkt_sink_fifo.sv
module pkt_sink_fifo
    import pkt_sink_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 16,
    parameter int THRESH   = 4,
    parameter int ADR_W    = 4,
    parameter int PAR_MODE = 1,
    localparam int MTY_W   = mty_bits(DATA_W),
    localparam int MTY_P   = at_least_one(MTY_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ena,
    input  logic [DATA_W-1:0] wr_dat,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic              wr_err,
    input  logic [MTY_P-1:0]  wr_mty,
    input  logic              wr_par,
    input  logic [ADR_W-1:0]  wr_adr,
    output logic              space_ok,
    output logic              ovf_flag,
    output logic              rd_valid,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_dat,
    output logic              rd_sop,
    output logic              rd_eop,
    output logic              rd_err,
    output logic [MTY_P-1:0]  rd_mty,
    output logic [ADR_W-1:0]  rd_adr
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic              err;
        logic [MTY_P-1:0]  mty;
        logic [ADR_W-1:0]  adr;
        logic [DATA_W-1:0] dat;
    } word_t;

    localparam int WORD_W = $bits(word_t);

    word_t             in_w;
    word_t             head_w;
    logic [WORD_W-1:0] head_vec;
    logic              st_en;
    logic              st_sop;
    logic              st_eop;
    logic              st_err;
    logic [MTY_P-1:0]  st_mty;
    logic [ADR_W-1:0]  st_adr;
    logic [DATA_W-1:0] st_dat;
    logic              full;
    logic              nonempty;
    logic [CNT_W-1:0]  count;

    pkt_sink_ingress #(
        .DATA_W  (DATA_W),
        .MTY_W   (MTY_W),
        .MTY_P   (MTY_P),
        .ADR_W   (ADR_W),
        .PAR_MODE(PAR_MODE)
    ) u_ingress (
        .clk   (clk),
        .rst   (rst),
        .wr_ena(wr_ena),
        .wr_dat(wr_dat),
        .wr_sop(wr_sop),
        .wr_eop(wr_eop),
        .wr_err(wr_err),
        .wr_mty(wr_mty),
        .wr_par(wr_par),
        .wr_adr(wr_adr),
        .full  (full),
        .st_en (st_en),
        .st_sop(st_sop),
        .st_eop(st_eop),
        .st_err(st_err),
        .st_mty(st_mty),
        .st_adr(st_adr),
        .st_dat(st_dat),
        .ovf   (ovf_flag)
    );

    assign in_w = '{sop: st_sop, eop: st_eop, err: st_err,
                    mty: st_mty, adr: st_adr, dat: st_dat};

    pkt_sink_store #(
        .WORD_W(WORD_W),
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .push     (st_en),
        .push_word(in_w),
        .pop_req  (rd_pop),
        .head_word(head_vec),
        .nonempty (nonempty),
        .full     (full),
        .count    (count)
    );

    pkt_sink_level #(
        .DEPTH (DEPTH),
        .THRESH(THRESH),
        .CNT_W (CNT_W)
    ) u_level (
        .count   (count),
        .space_ok(space_ok)
    );

    assign head_w   = head_vec;
    assign rd_valid = nonempty;
    assign rd_dat   = head_w.dat;
    assign rd_sop   = head_w.sop;
    assign rd_eop   = head_w.eop;
    assign rd_err   = head_w.err;
    assign rd_mty   = head_w.mty;
    assign rd_adr   = head_w.adr;

    // R10: the cycle after reset the buffer is empty and clean
    p_reset_clean_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_valid && space_ok && !ovf_flag));

    // R8: a presented word without the end flag carries no empty bytes
    p_mty_clean_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_eop) |-> (rd_mty == '0));

    // R2: an unpopped head word stays presented and unchanged
    p_head_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_pop) |=> (rd_valid && $stable(rd_dat) && $stable(rd_adr)));

    // R3: a full buffer never advertises space
    p_full_no_space_r3: assert property (@(posedge clk) disable iff (rst)
        full |-> !space_ok);

endmodule

// File: tb/tb_pkt_sink_fifo.sv
`timescale 1ns/1ps
module tb_pkt_sink_fifo;

    localparam int DW  = 32;
    localparam int MW  = 2;
    localparam int AW  = 4;
    localparam int DEP = 8;
    localparam int TH  = 3;
    localparam int EW  = 3 + MW + AW + DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ena = 1'b0;
    logic [DW-1:0] dat = '0;
    logic          sop = 1'b0;
    logic          eop = 1'b0;
    logic          err = 1'b0;
    logic [MW-1:0] mty = '0;
    logic          par = 1'b0;
    logic [AW-1:0] adr = '0;
    logic          pop = 1'b0;

    logic          space_ok, ovf_flag, rd_valid, rd_sop, rd_eop, rd_err;
    logic [DW-1:0] rd_dat;
    logic [MW-1:0] rd_mty;
    logic [AW-1:0] rd_adr;

    int checks = 0;
    int fails  = 0;

    logic [EW-1:0] q[$];
    bit m_ovf   = 1'b0;
    bit m_taint = 1'b0;

    always #4 clk = ~clk;

    pkt_sink_fifo #(
        .DATA_W(DW), .DEPTH(DEP), .THRESH(TH), .ADR_W(AW), .PAR_MODE(1)
    ) dut (
        .clk(clk), .rst(rst), .wr_ena(ena), .wr_dat(dat), .wr_sop(sop),
        .wr_eop(eop), .wr_err(err), .wr_mty(mty), .wr_par(par), .wr_adr(adr),
        .space_ok(space_ok), .ovf_flag(ovf_flag), .rd_valid(rd_valid),
        .rd_pop(pop), .rd_dat(rd_dat), .rd_sop(rd_sop), .rd_eop(rd_eop),
        .rd_err(rd_err), .rd_mty(rd_mty), .rd_adr(rd_adr)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        logic [EW-1:0] nw;
        bit            do_push;
        bit            pbad;
        bit            e_err;
        logic [MW-1:0] e_mty;
        int            sz;
        if (rst) begin
            q.delete();
            m_ovf   = 1'b0;
            m_taint = 1'b0;
        end else begin
            sz      = q.size();
            do_push = 1'b0;
            pbad    = (par != (^dat));
            if (ena) begin
                if (sz == DEP) begin
                    m_ovf   = 1'b1;
                    m_taint = 1'b1;
                end else begin
                    e_err   = err | pbad | (eop & m_taint);
                    e_mty   = eop ? mty : '0;
                    nw      = {sop, eop, e_err, e_mty, adr, dat};
                    do_push = 1'b1;
                    if (eop)       m_taint = 1'b0;
                    else if (pbad) m_taint = 1'b1;
                end
            end
            if (pop && sz > 0) void'(q.pop_front());
            if (do_push) q.push_back(nw);
        end
    endtask

    task automatic compare();
        logic [EW-1:0] h;
        chk(rd_valid, q.size() > 0, "R2 rd_valid");
        if (q.size() > 0) begin
            h = q[0];
            chk(rd_sop, h[EW-1], "R1 rd_sop");
            chk(rd_eop, h[EW-2], "R1 rd_eop");
            chk(rd_err, h[EW-3], "R7 R6 R9 rd_err");
            chk(rd_mty, h[MW+AW+DW-1 -: MW], "R8 rd_mty");
            chk(rd_adr, h[AW+DW-1 -: AW], "R12 rd_adr");
            chk(rd_dat, h[DW-1:0], "R1 rd_dat");
        end
        chk(space_ok, (DEP - q.size()) >= TH, "R3 space_ok");
        chk(ovf_flag, m_ovf, "R5 ovf_flag");
    endtask

    task automatic cycle();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic put(input bit s, input bit e, input bit er, input logic [MW-1:0] m,
                       input logic [AW-1:0] a, input logic [DW-1:0] d, input bit good,
                       input bit p);
        ena = 1'b1; sop = s; eop = e; err = er; mty = m; adr = a; dat = d;
        par = good ? (^d) : ~(^d);
        pop = p;
        cycle();
    endtask

    task automatic idle(input bit p);
        ena = 1'b0; dat = $urandom; sop = $urandom; eop = $urandom;
        err = $urandom; mty = $urandom; par = $urandom; adr = $urandom;
        pop = p;
        cycle();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 200000, 0);
        summary();
        $finish;
    end

    initial begin
        bit in_pkt;
        logic [AW-1:0] cur_adr;
        int seen;

        // reset
        rst = 1'b1;
        repeat (3) idle(1'b0);
        rst = 1'b0;
        idle(1'b0);
        chk(rd_valid, 1'b0, "R10 rd_valid after reset");
        chk(space_ok, 1'b1, "R10 space_ok after reset");
        chk(ovf_flag, 1'b0, "R10 ovf_flag after reset");

        // R1/R8/R12: short packet, junk idles, nonzero mty on a middle word
        put(1, 0, 0, 2'd0, 4'h5, 32'hA1B2C3D4, 1, 0);
        idle(0);
        put(0, 0, 0, 2'd3, 4'h5, 32'h11223344, 1, 0);
        idle(0);
        put(0, 1, 0, 2'd2, 4'h5, 32'h55660000, 1, 0);
        chk(rd_dat, 32'hA1B2C3D4, "R1 first word at head");
        chk(space_ok, 1'b1, "R3 three stored, five free");
        idle(1);
        chk(rd_mty, 2'd0, "R8 middle word mty cleaned");
        idle(1);
        chk(rd_mty, 2'd2, "R8 last word mty kept");
        chk(rd_adr, 4'h5, "R12 adr carried");
        idle(1);
        chk(rd_valid, 1'b0, "R2 empty after three pops");
        idle(1);
        idle(1);
        chk(rd_valid, 1'b0, "R2 pop on empty ignored");
        put(1, 1, 0, 2'd1, 4'h2, 32'hCAFE0000, 1, 0);
        chk(rd_valid, 1'b1, "R2 word visible after empty pops");
        idle(1);

        // R11: streaming write+pop
        put(1, 0, 0, 0, 4'h7, 32'h0, 1, 0);
        put(0, 0, 0, 0, 4'h7, 32'h1, 1, 0);
        for (int i = 2; i < 14; i++) begin
            put(0, i == 13, 0, 0, 4'h7, i, 1, 1);
            chk(rd_valid, 1'b1, "R11 stream keeps head");
            chk(space_ok, 1'b1, "R11 occupancy steady at two");
        end
        idle(1); idle(1);
        chk(rd_valid, 1'b0, "R11 stream drained");

        // R4/R5/R6: overrun a full buffer
        for (int i = 0; i < DEP + 3; i++) begin
            put(i == 0, 0, 0, 0, 4'h9, 32'h100 + i, 1, 0);
            if (i == DEP - TH) chk(space_ok, 1'b0, "R3 space drops below threshold");
        end
        chk(ovf_flag, 1'b1, "R5 overflow raised");
        chk(rd_dat, 32'h100, "R4 head intact after drops");
        put(0, 1, 0, 0, 4'h9, 32'h2FF, 1, 1);   // dropped, but pop proceeds
        chk(rd_dat, 32'h101, "R4 pop proceeds on full write");
        put(0, 1, 0, 0, 4'h9, 32'h300, 1, 0);   // stored end word
        seen = 0;
        while (rd_valid && seen < 20) begin
            if (rd_eop) chk(rd_err, 1'b1, "R6 damaged packet end marked");
            idle(1);
            seen++;
        end
        chk(seen, DEP, "R4 stored word count after overrun");
        put(1, 1, 0, 0, 4'h3, 32'h400, 1, 0);
        chk(rd_err, 1'b0, "R6 next packet clean");
        chk(ovf_flag, 1'b1, "R5 overflow still set");
        idle(1);

        // R9: bad parity in the middle word
        put(1, 0, 0, 0, 4'h4, 32'h0F0F0F01, 1, 0);
        put(0, 0, 0, 0, 4'h4, 32'h0F0F0F02, 0, 0);
        put(0, 1, 0, 1, 4'h4, 32'h0F0F0F03, 1, 0);
        chk(rd_err, 1'b0, "R9 good first word");
        idle(1);
        chk(rd_err, 1'b1, "R9 bad parity word marked");
        idle(1);
        chk(rd_err, 1'b1, "R9 end word of bad packet marked");
        idle(1);

        // R7: sender error carried
        put(1, 0, 1, 0, 4'h1, 32'h5, 1, 0);
        put(0, 1, 1, 3, 4'h1, 32'h6, 1, 0);
        put(1, 1, 0, 0, 4'h1, 32'h7, 1, 0);
        chk(rd_err, 1'b1, "R7 sender err kept");
        idle(1); idle(1);
        chk(rd_err, 1'b0, "R7 clean word after errored packet");
        idle(1);

        // random mix
        in_pkt  = 1'b0;
        cur_adr = '0;
        for (int i = 0; i < 1500; i++) begin
            if (($urandom % 3) != 0) begin
                bit e;
                if (!in_pkt) cur_adr = $urandom;
                e = (($urandom % 4) == 0);
                put(!in_pkt, e, (($urandom % 16) == 0), $urandom, cur_adr, $urandom,
                    (($urandom % 10) != 0), (($urandom % 5) < 2));
                in_pkt = !e;
            end else begin
                idle(($urandom % 2) == 0);
            end
        end

        // R5: reset clears the sticky flag
        rst = 1'b1;
        idle(0);
        rst = 1'b0;
        idle(0);
        chk(ovf_flag, 1'b0, "R5 reset clears overflow");
        chk(rd_valid, 1'b0, "R10 empty after second reset");

        summary();
        $finish;
    end

endmodule